// File: doc/BRIEF.md
# Memory Protection Entry Configuration Register Bank

This block stores the configuration for a small, parameterised set of memory protection entries. Each entry has an 8-bit configuration byte and a 32-bit address register. Software reaches both through a single-cycle CSR port with a request strobe, write enable, 12-bit CSR number, write data, combinational read data and an illegal-access flag. The block packs four configuration bytes into each 32-bit configuration CSR. It places the address registers at consecutive CSR numbers from a second base.

Every configuration write is legalised before it is stored. A byte is screened on its own lane against its entry's lock bit. Combinations that are not allowed are refused, and the reserved bits are never stored. Address writes are screened against the entry's own lock and against a locked top-of-range entry directly above it. The stored state is decoded into per-entry lock, match mode, permission and address outputs for a downstream access checker.

Top module: `pmp_regbank`

## Requirements
- R1: After reset, every configuration byte and every address register reads zero, and all decoded lock, mode and permission outputs are zero.
- R2: Configuration CSR number CFG_BASE+n holds the byte of entry 4n+k in bits 8k+7:8k. Within a byte, bit 7 is the lock, bits 4:3 are the match mode (00 off, 01 top-of-range, 10 four-byte, 11 power-of-two), bit 2 is execute, bit 1 is write and bit 0 is read. The decoded outputs mirror the stored byte.
- R3: Once an entry's lock bit (bit 7) is set, writes to its configuration byte and its address register are ignored until reset.
- R4: When entry i+1 is locked with mode 01 (top-of-range), writes to the address register of entry i are ignored. A locked entry with any other mode does not protect the entry below it.
- R5: Bits 6:5 of every configuration byte ignore writes and always read zero.
- R6: A configuration byte write with bit 0 = 0 and bit 1 = 1 (write without read) leaves the whole byte at its previous value.
- R7: With GRAIN_G > 0, a write selecting mode 10 keeps the previous mode value, and the byte's other fields still update.
- R8: Lanes of one configuration write are filtered independently, so unlocked entries sharing a CSR with a locked entry still update.
- R9: Any access made while not in machine mode raises csr_illegal in the same cycle, returns zero read data and changes nothing. So does an access to a CSR number outside the implemented configuration and address ranges.
- R10: Address CSR number ADR_BASE+i reads and writes the full 32-bit address register of entry i.
- R11: A read access changes no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| priv_m | input | 1 | Access is made in machine mode |
| csr_req | input | 1 | CSR access valid this cycle |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR number |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data (combinational, zero when illegal or idle) |
| csr_illegal | output | 1 | Access is illegal (combinational) |
| ent_lock | output | NUM_ENTRIES | Per-entry lock bit |
| ent_mode | output | 2*NUM_ENTRIES | Per-entry match mode, entry e in bits 2e+1:2e |
| ent_r | output | NUM_ENTRIES | Per-entry read permission |
| ent_w | output | NUM_ENTRIES | Per-entry write permission |
| ent_x | output | NUM_ENTRIES | Per-entry execute permission |
| ent_addr | output | 32*NUM_ENTRIES | Per-entry address register, entry e in bits 32e+31:32e |

## Verification
Lock filtering and legalisation can act on different lanes of the same configuration write. One CSR can hold a locked lane, a lane carrying the write-without-read pattern, a lane selecting the four-byte mode, and a plain lane. The bench provokes this with a single write to such a CSR that hits all four rules at once. It judges the result by reading the word back and comparing each lane with its rule. In the same spirit, an address write to the entry below a locked top-of-range entry is checked against one below a locked power-of-two entry, which must still accept the write.

// File: rtl/pmp_regbank_pkg.sv
// Shared types for the protection entry register bank.
// Assumes a 32-bit CSR data path and 12-bit CSR numbers.
package pmp_regbank_pkg;
    localparam int CSR_W  = 32;
    localparam int CSR_AW = 12;
    localparam int LANES  = CSR_W / 8;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_TOR   = 2'b01,
        MODE_NA4   = 2'b10,
        MODE_NAPOT = 2'b11
    } match_mode_e;

    typedef struct packed {
        logic        lock;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

    // Builds the visible byte; the reserved bits are always zero.
    function automatic logic [7:0] pack_cfg(input entry_cfg_t c);
        return {c.lock, 2'b00, c.mode, c.x, c.w, c.r};
    endfunction
endpackage

// File: rtl/pmp_csr_decode.sv
// CSR number decoder: classifies an access as a configuration hit,
// an address hit or illegal, and gives the offset from each base.
// Assumes both ranges sit wholly inside the 12-bit CSR space.
module pmp_csr_decode
    import pmp_regbank_pkg::*;
#(
    parameter int                NUM_ENTRIES = 8,
    parameter logic [CSR_AW-1:0] CFG_BASE    = 12'h3A0,
    parameter logic [CSR_AW-1:0] ADR_BASE    = 12'h3B0
) (
    input  logic              req,
    input  logic              priv_m,
    input  logic [CSR_AW-1:0] addr,
    output logic              cfg_hit,
    output logic              adr_hit,
    output logic [CSR_AW-1:0] cfg_off,
    output logic [CSR_AW-1:0] adr_off,
    output logic              illegal
);
    localparam int NUM_CFG = (NUM_ENTRIES + LANES - 1) / LANES;

    // Range checks against both CSR windows and privilege screening.
    always_comb begin
        cfg_off = addr - CFG_BASE;
        adr_off = addr - ADR_BASE;
        cfg_hit = (addr >= CFG_BASE) && (cfg_off < CSR_AW'(NUM_CFG));
        adr_hit = (addr >= ADR_BASE) && (adr_off < CSR_AW'(NUM_ENTRIES));
        illegal = req && (!priv_m || !(cfg_hit || adr_hit));
    end
endmodule

// File: rtl/pmp_cfg_entry.sv
// One entry's configuration byte with lock and legalisation rules.
// A locked byte ignores writes; a write-without-read byte is refused
// whole; the four-byte mode is refused (mode kept) when GRAIN_G > 0.
module pmp_cfg_entry
    import pmp_regbank_pkg::*;
#(
    parameter int GRAIN_G = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_byte,
    output entry_cfg_t cfg_q
);
    localparam bit NA4_BLOCKED = (GRAIN_G > 0);

    entry_cfg_t cfg_d;
    logic       rw_bad;
    logic       na4_bad;

    // Legalise the incoming byte against lock and reserved encodings.
    always_comb begin
        rw_bad  = !wr_byte[0] && wr_byte[1];
        na4_bad = NA4_BLOCKED && (wr_byte[4:3] == MODE_NA4);
        cfg_d   = cfg_q;
        if (wr_en && !cfg_q.lock && !rw_bad) begin
            cfg_d.lock = wr_byte[7];
            cfg_d.mode = na4_bad ? cfg_q.mode : match_mode_e'(wr_byte[4:3]);
            cfg_d.x    = wr_byte[2];
            cfg_d.w    = wr_byte[1];
            cfg_d.r    = wr_byte[0];
        end
    end

    // Configuration storage with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{lock: 1'b0, mode: MODE_OFF, x: 1'b0, w: 1'b0, r: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end
endmodule

// File: rtl/pmp_addr_entry.sv
// One entry's address register; a write lands only when not protected.
// Protection is computed by the parent from this and the next entry.
module pmp_addr_entry
    import pmp_regbank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_protect,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] addr_q
);
    // Address storage, updated by unprotected writes only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (wr_en && !wr_protect) begin
            addr_q <= wr_data;
        end
    end
endmodule

// File: rtl/pmp_regbank.sv
// Register bank for memory protection entries: configuration bytes
// packed four to a CSR plus one address CSR per entry, with per-lane
// lock filtering and top-of-range protection of the lower address.
// Assumes single-cycle CSR accesses and a 32-bit data path.
module pmp_regbank
    import pmp_regbank_pkg::*;
#(
    parameter int                NUM_ENTRIES = 8,
    parameter int                GRAIN_G     = 1,
    parameter logic [CSR_AW-1:0] CFG_BASE    = 12'h3A0,
    parameter logic [CSR_AW-1:0] ADR_BASE    = 12'h3B0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         priv_m,
    input  logic                         csr_req,
    input  logic                         csr_we,
    input  logic [CSR_AW-1:0]            csr_addr,
    input  logic [CSR_W-1:0]             csr_wdata,
    output logic [CSR_W-1:0]             csr_rdata,
    output logic                         csr_illegal,
    output logic [NUM_ENTRIES-1:0]       ent_lock,
    output logic [2*NUM_ENTRIES-1:0]     ent_mode,
    output logic [NUM_ENTRIES-1:0]       ent_r,
    output logic [NUM_ENTRIES-1:0]       ent_w,
    output logic [NUM_ENTRIES-1:0]       ent_x,
    output logic [CSR_W*NUM_ENTRIES-1:0] ent_addr
);
    logic              cfg_hit;
    logic              adr_hit;
    logic              illegal;
    logic [CSR_AW-1:0] cfg_off;
    logic [CSR_AW-1:0] adr_off;
    logic              do_wr;
    entry_cfg_t        cfg_q  [NUM_ENTRIES];
    logic [CSR_W-1:0]  addr_q [NUM_ENTRIES];

    pmp_csr_decode #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .CFG_BASE    (CFG_BASE),
        .ADR_BASE    (ADR_BASE)
    ) u_decode (
        .req     (csr_req),
        .priv_m  (priv_m),
        .addr    (csr_addr),
        .cfg_hit (cfg_hit),
        .adr_hit (adr_hit),
        .cfg_off (cfg_off),
        .adr_off (adr_off),
        .illegal (illegal)
    );

    assign do_wr       = csr_req && csr_we && !illegal;
    assign csr_illegal = illegal;

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
        logic cfg_wr;
        logic adr_wr;
        logic adr_protect;

        assign cfg_wr = do_wr && cfg_hit && (cfg_off == CSR_AW'(e / LANES));
        assign adr_wr = do_wr && adr_hit && (adr_off == CSR_AW'(e));

        if (e + 1 < NUM_ENTRIES) begin : g_upper
            assign adr_protect = cfg_q[e].lock ||
                                 (cfg_q[e+1].lock && cfg_q[e+1].mode == MODE_TOR);
        end else begin : g_top
            assign adr_protect = cfg_q[e].lock;
        end

        pmp_cfg_entry #(
            .GRAIN_G (GRAIN_G)
        ) u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cfg_wr),
            .wr_byte (csr_wdata[8*(e%LANES) +: 8]),
            .cfg_q   (cfg_q[e])
        );

        pmp_addr_entry u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (adr_wr),
            .wr_protect (adr_protect),
            .wr_data    (csr_wdata),
            .addr_q     (addr_q[e])
        );

        assign ent_lock[e]                = cfg_q[e].lock;
        assign ent_mode[2*e +: 2]         = cfg_q[e].mode;
        assign ent_r[e]                   = cfg_q[e].r;
        assign ent_w[e]                   = cfg_q[e].w;
        assign ent_x[e]                   = cfg_q[e].x;
        assign ent_addr[CSR_W*e +: CSR_W] = addr_q[e];
    end

    // Read multiplexer over packed configuration lanes and address registers.
    always_comb begin
        csr_rdata = '0;
        if (csr_req && !illegal) begin
            for (int e = 0; e < NUM_ENTRIES; e++) begin
                if (cfg_hit && cfg_off == CSR_AW'(e / LANES)) begin
                    csr_rdata[8*(e%LANES) +: 8] = pack_cfg(cfg_q[e]);
                end
                if (adr_hit && adr_off == CSR_AW'(e)) begin
                    csr_rdata = addr_q[e];
                end
            end
        end
    end
endmodule

// File: rtl/pmp_regbank_chk.sv
// Property checker for the register bank, bound to every instance.
module pmp_regbank_chk #(
    parameter int NUM_ENTRIES = 8,
    parameter int GRAIN_G     = 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      csr_req,
    input logic                      csr_we,
    input logic                      csr_illegal,
    input logic [31:0]               csr_rdata,
    input logic [NUM_ENTRIES-1:0]    ent_lock,
    input logic [2*NUM_ENTRIES-1:0]  ent_mode,
    input logic [NUM_ENTRIES-1:0]    ent_r,
    input logic [NUM_ENTRIES-1:0]    ent_w,
    input logic [NUM_ENTRIES-1:0]    ent_x,
    input logic [32*NUM_ENTRIES-1:0] ent_addr
);
    // R9: an illegal access returns zero data and leaves all state alone.
    a_r9_illegal_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |-> csr_rdata == 32'h0);
    a_r9_illegal_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal |=> $stable(ent_lock) && $stable(ent_mode) && $stable(ent_addr)
                        && $stable(ent_r) && $stable(ent_w) && $stable(ent_x));
    // R11: a read access changes no stored state.
    a_r11_read_no_change: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_req && !csr_we) |=> $stable(ent_lock) && $stable(ent_mode)
                                 && $stable(ent_addr) && $stable(ent_r)
                                 && $stable(ent_w) && $stable(ent_x));

    for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
        // R3: a locked entry keeps its fields and its address.
        a_r3_locked_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            ent_lock[e] |=> ent_lock[e] && $stable(ent_mode[2*e +: 2])
                            && $stable({ent_x[e], ent_w[e], ent_r[e]})
                            && $stable(ent_addr[32*e +: 32]));
        // R6: write without read is never stored.
        a_r6_no_w_without_r: assert property (@(posedge clk) disable iff (!rst_n)
            !(ent_w[e] && !ent_r[e]));
        if (GRAIN_G > 0) begin : g_grain
            // R7: four-byte mode is never stored under a coarse grain.
            a_r7_no_na4: assert property (@(posedge clk) disable iff (!rst_n)
                ent_mode[2*e +: 2] != 2'b10);
        end
        if (e >= 1) begin : g_tor
            // R4: locked top-of-range entry freezes the address below it.
            a_r4_tor_freezes_lower: assert property (@(posedge clk) disable iff (!rst_n)
                (ent_lock[e] && ent_mode[2*e +: 2] == 2'b01)
                |=> $stable(ent_addr[32*(e-1) +: 32]));
        end
    end
endmodule

bind pmp_regbank pmp_regbank_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .GRAIN_G     (GRAIN_G)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_req     (csr_req),
    .csr_we      (csr_we),
    .csr_illegal (csr_illegal),
    .csr_rdata   (csr_rdata),
    .ent_lock    (ent_lock),
    .ent_mode    (ent_mode),
    .ent_r       (ent_r),
    .ent_w       (ent_w),
    .ent_x       (ent_x),
    .ent_addr    (ent_addr)
);

// File: tb/test_pmp_regbank.sv
// Directed bench for the protection entry register bank.
module test_pmp_regbank;
    localparam int          N    = 8;
    localparam logic [11:0] CFG0 = 12'h3A0;
    localparam logic [11:0] CFG1 = 12'h3A1;
    localparam logic [11:0] ADR0 = 12'h3B0;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          priv_m = 1'b1;
    logic          csr_req = 1'b0;
    logic          csr_we = 1'b0;
    logic [11:0]   csr_addr = '0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          csr_illegal;
    logic [N-1:0]  ent_lock;
    logic [2*N-1:0] ent_mode;
    logic [N-1:0]  ent_r;
    logic [N-1:0]  ent_w;
    logic [N-1:0]  ent_x;
    logic [32*N-1:0] ent_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pmp_regbank #(.NUM_ENTRIES(N), .GRAIN_G(1)) i_pmp_regbank (
        .clk(clk), .rst_n(rst_n), .priv_m(priv_m), .csr_req(csr_req),
        .csr_we(csr_we), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata), .csr_illegal(csr_illegal), .ent_lock(ent_lock),
        .ent_mode(ent_mode), .ent_r(ent_r), .ent_w(ent_w), .ent_x(ent_x),
        .ent_addr(ent_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One access: drive after a falling edge, sample, commit at the rising edge.
    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] d,
                          input logic m, output logic [31:0] rd, output logic ill);
        @(negedge clk);
        csr_req = 1'b1; csr_we = we; csr_addr = a; csr_wdata = d; priv_m = m;
        #2;
        rd = csr_rdata; ill = csr_illegal;
        @(negedge clk);
        csr_req = 1'b0; csr_we = 1'b0; priv_m = 1'b1;
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd; logic ill;
        access(1'b1, a, d, 1'b1, rd, ill);
    endtask

    task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
        logic [31:0] rd; logic ill;
        access(1'b0, a, 32'h0, 1'b1, rd, ill);
        check(req, {31'h0, ill}, 32'h0);
        check(req, rd, exp);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 lock", {24'h0, ent_lock}, 32'h0);
        check("R1 mode", {16'h0, ent_mode}, 32'h0);
        check("R1 perms", {8'h0, ent_r, ent_w, ent_x}, 32'h0);
        rdchk("R1 cfg0", CFG0, 32'h0);
        rdchk("R1 cfg1", CFG1, 32'h0);
        for (int i = 0; i < N; i++) rdchk("R1 addr", ADR0 + 12'(i), 32'h0);
    endtask

    task automatic t_pack();
        wr(CFG0, 32'h01051B0F);
        rdchk("R2 cfg0 readback", CFG0, 32'h01051B0F);
        check("R2 entry1 mode", {30'h0, ent_mode[3:2]}, 32'h3);
        check("R2 entry0 mode", {30'h0, ent_mode[1:0]}, 32'h1);
        check("R2 entry2 x/w/r", {29'h0, ent_x[2], ent_w[2], ent_r[2]}, 32'h5);
        check("R2 entry3 x/w/r", {29'h0, ent_x[3], ent_w[3], ent_r[3]}, 32'h1);
    endtask

    task automatic t_reserved();
        wr(CFG1, 32'h00000061);
        rdchk("R5 reserved bits read zero", CFG1, 32'h00000001);
    endtask

    task automatic t_rw();
        wr(CFG0, 32'h01021B0F);
        rdchk("R6 write-without-read refused", CFG0, 32'h01051B0F);
        check("R6 entry2 w", {31'h0, ent_w[2]}, 32'h0);
    endtask

    task automatic t_na4();
        wr(CFG0, 32'h17051B0F);
        rdchk("R7 four-byte mode refused from off", CFG0, 32'h07051B0F);
        check("R7 entry3 mode", {30'h0, ent_mode[7:6]}, 32'h0);
        wr(CFG0, 32'h0705110F);
        rdchk("R7 mode kept, perms updated", CFG0, 32'h0705190F);
    endtask

    task automatic t_addr();
        for (int i = 0; i < N; i++) wr(ADR0 + 12'(i), 32'hA0000000 | 32'(i));
        for (int i = 0; i < N; i++) rdchk("R10 addr readback", ADR0 + 12'(i), 32'hA0000000 | 32'(i));
        check("R10 addr output", ent_addr[32*3 +: 32], 32'hA0000003);
    endtask

    task automatic t_illegal();
        logic [31:0] rd; logic ill;
        access(1'b1, CFG0, 32'h0, 1'b0, rd, ill);
        check("R9 user write flagged", {31'h0, ill}, 32'h1);
        rdchk("R9 user write no effect", CFG0, 32'h0705190F);
        access(1'b0, CFG0, 32'h0, 1'b0, rd, ill);
        check("R9 user read flagged", {31'h0, ill}, 32'h1);
        check("R9 user read zero data", rd, 32'h0);
        access(1'b1, ADR0, 32'h0, 1'b0, rd, ill);
        rdchk("R9 user addr write no effect", ADR0, 32'hA0000000);
        access(1'b1, 12'h3A2, 32'hFFFFFFFF, 1'b1, rd, ill);
        check("R9 unimplemented cfg flagged", {31'h0, ill}, 32'h1);
        access(1'b0, 12'h3B8, 32'h0, 1'b1, rd, ill);
        check("R9 unimplemented addr flagged", {31'h0, ill}, 32'h1);
        check("R9 unimplemented read zero", rd, 32'h0);
        access(1'b0, 12'h39F, 32'h0, 1'b1, rd, ill);
        check("R9 below range flagged", {31'h0, ill}, 32'h1);
        rdchk("R11 read left cfg0 intact", CFG0, 32'h0705190F);
    endtask

    // Lock filtering and legalisation acting on lanes of one write.
    task automatic t_lock();
        wr(CFG1, 32'h00008901);
        rdchk("R3 lock entry5 tor", CFG1, 32'h00008901);
        check("R3 entry5 lock out", {31'h0, ent_lock[5]}, 32'h1);
        wr(CFG1, 32'h17020003);
        rdchk("R8 lanes filtered independently", CFG1, 32'h07008903);
        wr(ADR0 + 12'd5, 32'h00005555);
        rdchk("R3 locked addr ignored", ADR0 + 12'd5, 32'hA0000005);
        wr(ADR0 + 12'd4, 32'h00004444);
        rdchk("R4 addr below tor lock ignored", ADR0 + 12'd4, 32'hA0000004);
        wr(ADR0 + 12'd6, 32'h00006666);
        rdchk("R4 addr above lock writable", ADR0 + 12'd6, 32'h00006666);
        wr(CFG1, 32'h9F008903);
        rdchk("R3 lock entry7 napot", CFG1, 32'h9F008903);
        wr(ADR0 + 12'd7, 32'h00007777);
        rdchk("R3 locked addr7 ignored", ADR0 + 12'd7, 32'hA0000007);
        wr(ADR0 + 12'd6, 32'h00006660);
        rdchk("R4 napot lock leaves lower writable", ADR0 + 12'd6, 32'h00006660);
        wr(CFG1, 32'h00000000);
        rdchk("R3 lock not clearable", CFG1, 32'h9F008900);
    endtask

    task automatic t_reset2();
        do_reset();
        rdchk("R3 reset clears lock", CFG1, 32'h0);
        check("R1 lock after reset", {24'h0, ent_lock}, 32'h0);
        rdchk("R1 addr after reset", ADR0 + 12'd5, 32'h0);
        wr(ADR0 + 12'd5, 32'h00000001);
        rdchk("R3 addr writable after reset", ADR0 + 12'd5, 32'h00000001);
        wr(CFG1, 32'h00000900);
        rdchk("R3 cfg writable after reset", CFG1, 32'h00000900);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_pack();
        t_reserved();
        t_rw();
        t_na4();
        t_addr();
        t_illegal();
        t_lock();
        t_reset2();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        #(100000 * 10);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule